// File: doc/BRIEF.md
# Scanline Interrupt Counter

This block lets a CPU ask for an interrupt after a chosen number of rendered video lines. Software writes a start value into an 8-bit down-counter and a reload value into a latch. It arms or disarms counting with two command addresses. The video unit sends one strobe per line, together with the current line number and a flag that is high while background or sprite display is on.

On every strobe that qualifies, the counter is tested and then stepped. A value of zero before the step reloads the counter from the latch and sets the interrupt request. Any other value is decremented. The request is a level that stays high until software writes the disarm address. Only address bits 15, 14, 13 and 0 are decoded, so each command appears at many mirrored addresses.

Top module: `scanline_irq_counter`

## Requirements
- R1: While reset is active, the enable, the counter and the latch clear to zero and `irq` is low.
- R2: A write whose address ANDed with 0xE001 equals 0xC000 loads `wr_data` into the counter.
- R3: A write whose masked address equals 0xC001 loads the latch. The new value is used at the next reload and does not change the running count.
- R4: A write whose masked address equals 0xE001 enables counting, whatever the data value.
- R5: A write whose masked address equals 0xE000 disables counting and drops `irq` on the next cycle, whatever the data value.
- R6: A strobe with `line_num` above 239 leaves the counter and `irq` unchanged. Lines 0 through 239 qualify.
- R7: A strobe while `render_on` is low, or while counting is disabled, leaves the counter and `irq` unchanged.
- R8: A qualifying strobe that finds the counter at zero reloads it from the latch and sets `irq` on the cycle after the strobe.
- R9: A qualifying strobe that finds a nonzero counter decrements it by one and does not raise `irq`.
- R10: When a counter write and a strobe fall in the same cycle, the written value is kept and the strobe is dropped. The same holds for a disable write and a strobe in the same cycle.
- R11: Once set, `irq` stays high through further strobes and other writes until a disable write.
- R12: Writes whose masked address matches none of the four codes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| line_tick | input | 1 | One-cycle pulse per video line |
| line_num | input | 9 | Current line number |
| render_on | input | 1 | High while background or sprite display is enabled |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit counter, 9-bit line numbers, 239 as the last visible line and the 0xE001 decode mask. The 9-bit line field lets the stimulus reach lines 240 and higher, which gives direct coverage of the visible-line cut-off. The 8-bit counter keeps reload periods short enough that random runs hit many reloads, as well as same-cycle collisions between writes and strobes.

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter #(
  parameter int CNT_W     = 8,
  parameter int LINE_W    = 9,
  parameter int LAST_LINE = 239,
  parameter int ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] DEC_MASK = 16'hE001,
  parameter logic [ADDR_W-1:0] A_COUNT  = 16'hC000,
  parameter logic [ADDR_W-1:0] A_LATCH  = 16'hC001,
  parameter logic [ADDR_W-1:0] A_OFF    = 16'hE000,
  parameter logic [ADDR_W-1:0] A_ON     = 16'hE001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              line_tick,
  input  logic [LINE_W-1:0] line_num,
  input  logic              render_on,
  output logic              irq
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] latch;
  logic             enable;

  wire [ADDR_W-1:0] dec      = wr_addr & DEC_MASK;
  wire              wr_cnt   = wr_en && (dec == A_COUNT);
  wire              wr_latch = wr_en && (dec == A_LATCH);
  wire              wr_off   = wr_en && (dec == A_OFF);
  wire              wr_on    = wr_en && (dec == A_ON);

  wire visible = line_num <= LINE_W'(LAST_LINE);
  wire step    = line_tick && enable && render_on && visible && !wr_cnt && !wr_off;
  wire hit     = step && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (wr_cnt) begin
      cnt <= wr_data;
    end else if (step) begin
      cnt <= hit ? latch : cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        latch <= '0;
    else if (wr_latch) latch <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      enable <= 1'b0;
    else if (wr_off) enable <= 1'b0;
    else if (wr_on)  enable <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      irq <= 1'b0;
    else if (wr_off) irq <= 1'b0;
    else if (hit)    irq <= 1'b1;
  end

endmodule

// File: rtl/scanline_irq_counter_chk.sv
module scanline_irq_counter_chk #(
  parameter int CNT_W     = 8,
  parameter int LINE_W    = 9,
  parameter int LAST_LINE = 239,
  parameter int ADDR_W    = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [CNT_W-1:0]  wr_data,
  input logic              line_tick,
  input logic [LINE_W-1:0] line_num,
  input logic              render_on,
  input logic              irq,
  input logic [CNT_W-1:0]  cnt,
  input logic              enable
);

  wire [3:0] sel  = {wr_addr[15:13], wr_addr[0]};
  wire       c_ld  = wr_en && sel == 4'b1100;
  wire       c_off = wr_en && sel == 4'b1110;
  wire       c_on  = wr_en && sel == 4'b1111;

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (irq == 1'b0 && cnt == '0 && enable == 1'b0));

  assert_count_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    c_ld |=> cnt == $past(wr_data));

  assert_enable_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    c_on |=> enable);

  assert_disable_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    c_off |=> (!enable && !irq));

  assert_invisible_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (line_num > LINE_W'(LAST_LINE) && !c_ld) |=> $stable(cnt));

  assert_blank_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!render_on && !c_ld) |=> $stable(cnt));

  assert_rise_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(line_tick && render_on && enable && line_num <= LINE_W'(LAST_LINE)));

  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !c_off) |=> irq);

endmodule

bind scanline_irq_counter scanline_irq_counter_chk #(
  .CNT_W(CNT_W), .LINE_W(LINE_W), .LAST_LINE(LAST_LINE), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .line_tick(line_tick), .line_num(line_num), .render_on(render_on),
  .irq(irq), .cnt(cnt), .enable(enable)
);

// File: tb/scanline_irq_counter_bench.sv
`timescale 1ns/1ps
module scanline_irq_counter_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        line_tick = 1'b0;
  logic [8:0]  line_num = '0;
  logic        render_on = 1'b0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic       m_en, m_irq;
  logic [7:0] m_cnt, m_lat;

  always #10 clk = ~clk;

  scanline_irq_counter u_scanline_irq_counter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .line_tick(line_tick), .line_num(line_num), .render_on(render_on), .irq(irq)
  );

  // 0 none, 1 counter, 2 latch, 3 disable, 4 enable
  function automatic int decode(input logic we, input logic [15:0] a);
    if (!we) return 0;
    case ({a[15:13], a[0]})
      4'b1100: return 1;
      4'b1101: return 2;
      4'b1110: return 3;
      4'b1111: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic bit qualifies(input logic tk, input logic [8:0] ln, input logic ro,
                                   input logic en);
    return tk && ro && en && (ln <= 9'd239);
  endfunction

  task automatic check(input string tag, input logic exp);
    checks++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s irq=%b expected=%b at %0t", tag, irq, exp, $time);
    end
  endtask

  task automatic cyc(input logic we, input logic [15:0] a, input logic [7:0] d,
                     input logic tk, input logic [8:0] ln, input logic ro, input string tag);
    int op;
    bit st;
    wr_en = we; wr_addr = a; wr_data = d;
    line_tick = tk; line_num = ln; render_on = ro;
    op = decode(we, a);
    st = qualifies(tk, ln, ro, m_en) && op != 1 && op != 3;
    if (op == 1) m_cnt = d;
    else if (st) begin
      if (m_cnt == 8'd0) begin m_cnt = m_lat; m_irq = 1'b1; end
      else m_cnt = m_cnt - 8'd1;
    end
    if (op == 2) m_lat = d;
    if (op == 3) begin m_en = 1'b0; m_irq = 1'b0; end
    if (op == 4) m_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; line_tick = 1'b0;
    check(tag, m_irq);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
    cyc(1'b1, a, d, 1'b0, 9'd0, 1'b1, tag);
  endtask

  task automatic tick(input logic [8:0] ln, input logic ro, input string tag);
    cyc(1'b0, 16'h0000, 8'h00, 1'b1, ln, ro, tag);
  endtask

  initial begin
    int unused;
    unused = $urandom(32'd1234);
    m_en = 0; m_irq = 0; m_cnt = 0; m_lat = 0;
    repeat (3) @(negedge clk);
    check("R1", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 1'b0);

    wr(16'hE001, 8'h00, "R4");
    tick(9'd10, 1'b1, "R1");
    tick(9'd11, 1'b1, "R11");
    wr(16'hE000, 8'h5A, "R5");

    wr(16'hC001, 8'd3, "R3");
    wr(16'hC000, 8'd2, "R2");
    wr(16'hE001, 8'hFF, "R4");
    tick(9'd0, 1'b1, "R9");
    tick(9'd1, 1'b1, "R9");
    tick(9'd2, 1'b1, "R8");
    wr(16'hC001, 8'd1, "R11");
    wr(16'hE000, 8'h00, "R5");
    wr(16'hE001, 8'h00, "R4");
    tick(9'd3, 1'b1, "R9");
    tick(9'd4, 1'b1, "R9");
    tick(9'd5, 1'b1, "R9");
    tick(9'd6, 1'b1, "R3");
    wr(16'hE000, 8'h00, "R5");

    wr(16'hE001, 8'h00, "R4");
    wr(16'hC000, 8'd0, "R2");
    tick(9'd240, 1'b1, "R6");
    tick(9'd300, 1'b1, "R6");
    tick(9'd100, 1'b0, "R7");
    tick(9'd239, 1'b1, "R6");
    wr(16'hE000, 8'h00, "R5");
    wr(16'hC000, 8'd0, "R2");
    tick(9'd20, 1'b1, "R7");
    wr(16'hE001, 8'h00, "R4");

    cyc(1'b1, 16'hC000, 8'd1, 1'b1, 9'd50, 1'b1, "R10");
    tick(9'd51, 1'b1, "R10");
    tick(9'd52, 1'b1, "R10");
    wr(16'hE000, 8'h00, "R5");
    wr(16'hE001, 8'h00, "R4");
    wr(16'hC000, 8'd0, "R2");
    cyc(1'b1, 16'hE000, 8'd0, 1'b1, 9'd60, 1'b1, "R10");

    wr(16'hE001, 8'h00, "R4");
    wr(16'hDFFE, 8'd1, "R12");
    wr(16'hA000, 8'd0, "R12");
    wr(16'h8001, 8'd0, "R12");
    tick(9'd70, 1'b1, "R12");
    tick(9'd71, 1'b1, "R12");
    wr(16'hFFFE, 8'd0, "R12");

    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      logic [8:0] ln;
      int r;
      bit we;
      r = $urandom_range(0, 15);
      case (r % 6)
        0: a = 16'hC000;
        1: a = 16'hC001;
        2: a = 16'hE000;
        3: a = 16'hE001;
        4: a = 16'h8000;
        default: a = 16'($urandom);
      endcase
      a[12:1] = 12'($urandom);
      we = ($urandom_range(0, 9) < 2) && !(r % 6 == 2 && $urandom_range(0, 3) != 0);
      ln = ($urandom_range(0, 4) == 0) ? 9'($urandom_range(240, 511)) : 9'($urandom_range(0, 239));
      cyc(we, a, 8'($urandom_range(0, 6)), $urandom_range(0, 2) != 0, ln,
          $urandom_range(0, 7) != 0, "R8");
    end
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule